// File: doc/BRIEF.md
# Parallel Byte Bitstream Receiver

This block takes a compressed bitstream from a host controller one byte at a time over an 8-bit data bus. A three-wire handshake moves the bytes. The receiver drives a request line while it has room for a bundle of bytes. The host places a byte on the bus and raises its enable line. The receiver answers each byte it takes with an acknowledge pulse. Accepted bytes go into an internal first-word-fall-through FIFO, and a downstream consumer drains that FIFO through a simple read port.

The request line follows the free space in the FIFO, with hysteresis set by two threshold inputs. The request can close while the host is in the middle of a bundle. A byte that the host offers after the request has closed gets no acknowledge and is discarded, so the host must send it again.

The enable line and the data bus cross into the receiver clock domain through two-flop synchronisers. A soft clear empties the FIFO, drops the request and returns the handshake to idle.

The handshake controller has four states:
- HS_IDLE: the acknowledge is low and the controller waits for the synchronised enable.
- HS_SETTLE: a one-cycle wait, after which the synchronised byte is written to the FIFO.
- HS_ACK: the acknowledge is high until the synchronised enable falls.
- HS_REFUSE: the acknowledge stays low until the synchronised enable falls.

The transitions are:
- IDLE→SETTLE: enable is seen high while the request is high and the FIFO is not full.
- IDLE→REFUSE: enable is seen high while the request is low or the FIFO is full.
- SETTLE→ACK: always, after one cycle.
- ACK→IDLE: enable is seen low.
- REFUSE→IDLE: enable is seen low.
- any state→IDLE: soft clear.

Top module: `pbyte_rx`

## Requirements
- R1: After reset, `host_req`, `host_ack` and `rd_valid` are all low.
- R2: When the request is low and the FIFO free space (DEPTH minus the stored count) is at least `cfg_hi_free`, the request rises one cycle later.
- R3: When the request is high, it stays high while free space is at least `cfg_lo_free`, and it falls one cycle after free space drops below `cfg_lo_free`. Use requires `cfg_lo_free` ≤ `cfg_hi_free` ≤ DEPTH.
- R4: `host_ack` rises only when the synchronised enable is high and the byte has been written.
- R5: Once raised, `host_ack` stays high until the synchronised enable is low. The controller then returns to idle with `host_ack` low.
- R6: A byte offered while the request is low (or the FIFO is full) receives no acknowledge and is not stored.
- R7: Accepted bytes leave on `rd_data` in arrival order with bit positions unchanged (bit 7 is the MSB). `rd_valid` is high while the FIFO holds data, and `rd_en` with `rd_valid` high pops one byte.
- R8: While `soft_clr` is high, the FIFO is emptied, the handshake returns to idle and the request is held low.
- R9: No write ever occurs while the FIFO is full.
- R10: When `host_en` rises with the request open, `host_ack` is seen high after exactly the fourth rising clock edge: two edges for synchronisation, one for the idle decision and one for the settle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of FIFO, handshake and request |
| host_en | input | 1 | Host data-valid strobe (asynchronous) |
| host_data | input | 8 | Host byte, bit 7 is MSB |
| host_req | output | 1 | Receiver asks for bytes |
| host_ack | output | 1 | Receiver has taken the current byte |
| cfg_hi_free | input | CNT_W | Free-space level that opens the request |
| cfg_lo_free | input | CNT_W | Free-space level below which the request closes |
| rd_en | input | 1 | Consumer pops the head byte |
| rd_data | output | 8 | Head byte of the FIFO |
| rd_valid | output | 1 | FIFO not empty |

## Verification
The bench builds the block with DEPTH 8, which makes CNT_W equal to 4. With FIFO this shallow, every pair of thresholds with 1 ≤ low ≤ high ≤ 8 can be swept in turn. Each sweep fills the FIFO until the request closes and then offers one more byte, which must be refused. The bench then drains the FIFO and checks the data order and the point at which the request reopens against an arithmetic occupancy model. The first byte of each sweep also checks the synchroniser latency, and a soft clear in the middle of a fill is exercised.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
    typedef enum logic [1:0] {
        HS_IDLE   = 2'd0,
        HS_SETTLE = 2'd1,
        HS_ACK    = 2'd2,
        HS_REFUSE = 2'd3
    } hs_state_t;
endpackage

// File: rtl/pbr_sync.sv
module pbr_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[s] <= '0;
                end else if (s == 0) begin
                    chain_q[s] <= d_async;
                end else begin
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pbr_fifo.sv
module pbr_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              not_empty,
    output logic              full,
    output logic [CNT_W-1:0]  count
);
    localparam logic [AW-1:0]    LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [AW-1:0]     wptr_q, rptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              do_wr, do_rd;

    assign full      = (cnt_q == FULL_CNT);
    assign not_empty = (cnt_q != '0);
    assign do_wr     = wr_en && !full && !clr;
    assign do_rd     = rd_en && not_empty && !clr;
    assign rd_data   = mem_q[rptr_q];
    assign count     = cnt_q;

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem_q[wptr_q] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else if (clr) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_wr) begin
                wptr_q <= (wptr_q == LAST_IDX) ? '0 : wptr_q + 1'b1;
            end
            if (do_rd) begin
                rptr_q <= (rptr_q == LAST_IDX) ? '0 : rptr_q + 1'b1;
            end
            unique case ({do_wr, do_rd})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        full && !clr && !do_rd |=> full && (cnt_q == FULL_CNT));

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);

    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !not_empty);
endmodule

// File: rtl/pbr_req_ctrl.sv
module pbr_req_ctrl #(
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] hi_free,
    input  logic [CNT_W-1:0] lo_free,
    output logic             req
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

    logic [CNT_W-1:0] free_space;
    logic             req_q, req_d;

    assign free_space = CAP - count;

    always_comb begin
        req_d = req_q;
        if (clr) begin
            req_d = 1'b0;
        end else if (!req_q && (free_space >= hi_free)) begin
            req_d = 1'b1;
        end else if (req_q && (free_space < lo_free)) begin
            req_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= req_d;
        end
    end

    assign req = req_q;

    assert_req_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_q && !clr && (free_space >= hi_free) |=> req_q);

    assert_req_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_q && !clr && (free_space >= lo_free) |=> req_q);

    assert_req_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_q && !clr && (free_space < lo_free) |=> !req_q);

    assert_clear_drops_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !req_q);
endmodule

// File: rtl/pbyte_rx.sv
module pbyte_rx
    import pbr_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 8,
    parameter int SYNC_ST = 2,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              host_en,
    input  logic [DATA_W-1:0] host_data,
    output logic              host_req,
    output logic              host_ack,
    input  logic [CNT_W-1:0]  cfg_hi_free,
    input  logic [CNT_W-1:0]  cfg_lo_free,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    hs_state_t         state_q, state_d;
    logic              en_s;
    logic [DATA_W-1:0] data_s;
    logic              fifo_wr, fifo_full;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              req_w;

    pbr_sync #(.WIDTH(1), .STAGES(SYNC_ST)) u_en_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (host_en),
        .q_sync  (en_s)
    );

    pbr_sync #(.WIDTH(DATA_W), .STAGES(SYNC_ST)) u_data_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (host_data),
        .q_sync  (data_s)
    );

    pbr_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (soft_clr),
        .wr_en     (fifo_wr),
        .wr_data   (data_s),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .not_empty (rd_valid),
        .full      (fifo_full),
        .count     (fifo_cnt)
    );

    pbr_req_ctrl #(.DEPTH(DEPTH)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (soft_clr),
        .count   (fifo_cnt),
        .hi_free (cfg_hi_free),
        .lo_free (cfg_lo_free),
        .req     (req_w)
    );

    assign host_req = req_w;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (soft_clr) begin
            state_d = HS_IDLE;
        end else begin
            unique case (state_q)
                HS_IDLE: begin
                    if (en_s) begin
                        state_d = (req_w && !fifo_full) ? HS_SETTLE : HS_REFUSE;
                    end
                end
                HS_SETTLE: state_d = HS_ACK;
                HS_ACK: begin
                    if (!en_s) state_d = HS_IDLE;
                end
                HS_REFUSE: begin
                    if (!en_s) state_d = HS_IDLE;
                end
                default: state_d = HS_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        host_ack = 1'b0;
        fifo_wr  = 1'b0;
        unique case (state_q)
            HS_IDLE:   ;
            HS_SETTLE: fifo_wr  = 1'b1;
            HS_ACK:    host_ack = 1'b1;
            HS_REFUSE: ;
            default:   ;
        endcase
    end

    assert_ack_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_ack) |-> en_s);

    assert_ack_follows_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_ack) |-> $past(fifo_wr));

    assert_ack_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack && en_s && !soft_clr |=> host_ack);

    assert_ack_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack && !en_s |=> !host_ack);

    assert_refuse_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == HS_IDLE && en_s && !req_w |=> !fifo_wr && !host_ack);
endmodule

// File: tb/pbyte_rx_bench.sv
module pbyte_rx_bench;
    localparam int DEPTH = 8;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             soft_clr = 1'b0;
    logic             host_en = 1'b0;
    logic [7:0]       host_data = '0;
    logic             host_req, host_ack;
    logic [CNT_W-1:0] cfg_hi_free = CNT_W'(DEPTH);
    logic [CNT_W-1:0] cfg_lo_free = CNT_W'(1);
    logic             rd_en = 1'b0;
    logic [7:0]       rd_data;
    logic             rd_valid;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pbyte_rx #(.DATA_W(8), .DEPTH(DEPTH)) u_pbyte_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_clr    (soft_clr),
        .host_en     (host_en),
        .host_data   (host_data),
        .host_req    (host_req),
        .host_ack    (host_ack),
        .cfg_hi_free (cfg_hi_free),
        .cfg_lo_free (cfg_lo_free),
        .rd_en       (rd_en),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model
    logic [7:0] mq [DEPTH];
    int mhead = 0, mocc = 0;
    bit mreq = 0;
    int hi_v, lo_v;

    function automatic void model_req();
        int fr;
        fr = DEPTH - mocc;
        if (!mreq && fr >= hi_v) mreq = 1;
        else if (mreq && fr < lo_v) mreq = 0;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Offer one byte; returns whether acknowledged and edges to ack.
    task automatic offer(input logic [7:0] b, output bit acked, output int lat);
        acked = 0;
        lat = 0;
        @(negedge clk);
        host_data = b;
        host_en = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (host_ack) begin
                acked = 1;
                break;
            end
        end
        host_en = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!host_ack) break;
        end
        idle(3);
    endtask

    task automatic pop_check(input string tag);
        check({tag, " R7 valid"}, int'(rd_valid), 1);
        check({tag, " R7 data"}, int'(rd_data), int'(mq[mhead]));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        mhead = (mhead + 1) % DEPTH;
        mocc--;
        idle(3);
        model_req();
        check({tag, " R2/R3 req after pop"}, int'(host_req), int'(mreq));
    endtask

    task automatic do_clear();
        @(negedge clk);
        soft_clr = 1'b1;
        @(negedge clk);
        check("R8 req low in clear", int'(host_req), 0);
        check("R8 fifo empty in clear", int'(rd_valid), 0);
        check("R8 ack low in clear", int'(host_ack), 0);
        soft_clr = 1'b0;
        mhead = 0;
        mocc = 0;
        mreq = 0;
        model_req();
        idle(3);
        check("R2 req after clear", int'(host_req), int'(mreq));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        bit acked;
        int lat;
        idle(3);
        check("R1 req at reset", int'(host_req), 0);
        check("R1 ack at reset", int'(host_ack), 0);
        check("R1 valid at reset", int'(rd_valid), 0);
        rst_n = 1'b1;

        for (int hi = 1; hi <= DEPTH; hi++) begin
            for (int lo = 1; lo <= hi; lo++) begin
                hi_v = hi;
                lo_v = lo;
                cfg_hi_free = CNT_W'(hi);
                cfg_lo_free = CNT_W'(lo);
                do_clear();
                // fill until refused
                for (int k = 0; k < DEPTH + 2; k++) begin
                    logic [7:0] b;
                    bit exp_acc;
                    b = 8'((hi << 5) ^ (lo << 2) ^ (k * 8'h47) ^ 8'h80);
                    exp_acc = mreq && (mocc < DEPTH);
                    offer(b, acked, lat);
                    check(exp_acc ? "R4 accepted" : "R6 refused", int'(acked), int'(exp_acc));
                    if (k == 0 && exp_acc) check("R10 ack latency", lat, 4);
                    if (exp_acc) begin
                        mq[(mhead + mocc) % DEPTH] = b;
                        mocc++;
                    end
                    check("R5 ack low after release", int'(host_ack), 0);
                    model_req();
                    check("R3 req after byte", int'(host_req), int'(mreq));
                    if (!exp_acc) break;
                end
                // drain
                while (mocc > 0) pop_check("drain");
                check("R7 empty after drain", int'(rd_valid), 0);
            end
        end

        // soft clear in the middle of a fill
        hi_v = DEPTH;
        lo_v = 1;
        cfg_hi_free = CNT_W'(DEPTH);
        cfg_lo_free = CNT_W'(1);
        do_clear();
        for (int k = 0; k < 3; k++) begin
            offer(8'(8'hA0 + k), acked, lat);
            check("R4 pre-clear accept", int'(acked), 1);
        end
        do_clear();
        check("R8 fifo empty after clear", int'(rd_valid), 0);
        offer(8'h5A, acked, lat);
        check("R8 accepts after clear", int'(acked), 1);
        mq[0] = 8'h5A;
        mocc = 1;
        pop_check("post-clear");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule